// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block turns one bus request from the core of an 8-bit processor into the cycle-by-cycle strobe pattern on the external bus. Each clock is one T-state. A request names a cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then drives the address, the write data and the six active-low strobes (opcode fetch marker, memory request, I/O request, read, write, refresh) for the whole cycle. It captures read data and reports completion with a one-clock pulse.

Opcode fetches are one T-state longer than plain memory reads. Their second half is a refresh phase: the address bus carries the interrupt-vector byte (an input) above the block's own refresh counter, with the refresh and memory-request strobes active. The counter advances its low seven bits once per fetch, and its top bit holds whatever was last loaded. When the core reports that it is halted, the fetch runs normally on the bus but hands back a zero opcode and does not ask for the program counter to advance. I/O cycles use the I/O request strobe in place of the memory request strobe and last three T-states longer than a memory access.

Top module: `busSequencer`

## Requirements
- R1: After reset all six strobes are high, `idle` is 1, `refreshVal`, `rdData`, `done` and `pcStep` are 0, and `busAddr` and `busDataOut` are 0.
- R2: A memory read (kind code 1) lasts 3 T-states; in T1 the address is on `busAddr` with all strobes high; in T2 and T3 `mreqN` and `rdN` are low; `busDataIn` is captured at the end of T3 and appears on `rdData` in the clock after T3, together with a one-clock `done`.
- R3: A memory write (kind code 2) lasts 3 T-states; `busDataOut` carries the write byte in T1 to T3; `mreqN` and `wrN` are low in T2 and T3; `done` follows T3 and `rdData` keeps its previous value. Outside write cycles `busDataOut` is 0.
- R4: An opcode fetch (kind code 0) lasts 4 T-states; `m1N` is low in T1 and T2; `mreqN` and `rdN` are low in T2; `busDataIn` is captured at the end of T2 and shown on `rdData` with `done` after T4.
- R5: In T3 and T4 of a fetch, `busAddr` is {`ivReg`, refresh counter value before the step}, `rfshN` and `mreqN` are low and `m1N`, `rdN` are high.
- R6: At the end of every fetch the low 7 bits of the refresh counter increment (wrapping 0x7F to 0x00) while bit 7 keeps its value; `refreshLoad` loads the full 8-bit value only while idle; the counter is visible on `refreshVal`.
- R7: A fetch requested with `haltFlag` high returns 0x00 on `rdData` and leaves `pcStep` low; a fetch with `haltFlag` low pulses `pcStep` together with `done`; other kinds never pulse `pcStep`.
- R8: I/O read (code 3) and I/O write (code 4) last 6 T-states; `iorqN` is low with `rdN` or `wrN` in T2 to T6, `mreqN` stays high; I/O read data is captured at the end of T6.
- R9: Kind codes 5, 6 and 7 start no cycle: `idle` stays 1 and no strobe or `done` is driven.
- R10: A request is accepted only while `idle` is 1; requests presented during a cycle are ignored, and exactly one cycle runs at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 3 | Cycle kind: 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write |
| reqAddr | input | 16 | Cycle address |
| reqWrData | input | 8 | Write data |
| haltFlag | input | 1 | Core is halted; sampled with a fetch request |
| ivReg | input | 8 | Interrupt-vector byte for the refresh address |
| refreshLoad | input | 1 | Load the refresh counter (idle only) |
| refreshLoadVal | input | 8 | Value for the refresh counter |
| busDataIn | input | 8 | Data bus from memory or I/O |
| busAddr | output | 16 | Address bus |
| busDataOut | output | 8 | Data bus towards memory or I/O |
| m1N | output | 1 | Opcode fetch marker, active low |
| mreqN | output | 1 | Memory request, active low |
| iorqN | output | 1 | I/O request, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| rfshN | output | 1 | Refresh strobe, active low |
| rdData | output | 8 | Captured read data |
| done | output | 1 | One-clock pulse after the last T-state |
| pcStep | output | 1 | Program counter may advance (with done) |
| idle | output | 1 | Ready for a request |
| refreshVal | output | 8 | Refresh counter value |

## Verification
The hardest situation to reach is the refresh counter's top bit surviving a wrap of the low seven bits, since counting up from reset never sets it; the bench loads 0xFF while idle and then runs a fetch, expecting 0xFF on the low address byte during refresh and 0x80 afterwards. A second awkward case is a request arriving mid-cycle: the bench raises a write request during T2 of a read and withdraws it in the final T-state, then checks that the read finishes unchanged and that no write strobe or data follows.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    KIND_FETCH  = 3'd0,
    KIND_MEM_RD = 3'd1,
    KIND_MEM_WR = 3'd2,
    KIND_IO_RD  = 3'd3,
    KIND_IO_WR  = 3'd4
  } cycKindT;

  // Control-to-datapath strobes, all active high.
  typedef struct packed {
    logic idle;
    logic accept;
    logic m1;
    logic mreq;
    logic iorq;
    logic rd;
    logic wr;
    logic rfsh;
    logic capture;
    logic forceZero;
    logic bumpRefresh;
    logic finish;
    logic stepPc;
    logic driveData;
  } seqStrobesT;

  function automatic logic kindLegal(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
#(
  parameter int MEM_T    = 3,
  parameter int IO_EXTRA = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       haltFlag,
  output seqStrobesT strb
);

  localparam int FETCH_T = MEM_T + 1;
  localparam int IO_T    = MEM_T + IO_EXTRA;
  localparam int RD_END  = FETCH_T - 2;   // last T-state of the fetch read phase
  localparam int T_W     = $clog2(IO_T + 1);

  logic           busy;
  logic           haltQ;
  cycKindT        kindQ;
  logic [T_W-1:0] tCnt;
  logic [T_W-1:0] lastT;
  logic           isFinal;
  logic           strobePhase;

  always_comb begin
    case (kindQ)
      KIND_FETCH:            lastT = T_W'(FETCH_T);
      KIND_IO_RD, KIND_IO_WR: lastT = T_W'(IO_T);
      default:               lastT = T_W'(MEM_T);
    endcase
  end

  assign isFinal     = busy && (tCnt == lastT);
  assign strobePhase = busy && (tCnt >= T_W'(2));

  always_comb begin
    strb        = '0;
    strb.idle   = !busy;
    strb.accept = !busy && reqValid && kindLegal(reqKind);
    strb.finish = isFinal;
    if (busy) begin
      case (kindQ)
        KIND_FETCH: begin
          strb.m1          = tCnt <= T_W'(RD_END);
          strb.mreq        = strobePhase;
          strb.rd          = strobePhase && (tCnt <= T_W'(RD_END));
          strb.rfsh        = tCnt > T_W'(RD_END);
          strb.capture     = tCnt == T_W'(RD_END);
          strb.forceZero   = haltQ;
          strb.bumpRefresh = isFinal;
          strb.stepPc      = !haltQ;
        end
        KIND_MEM_RD: begin
          strb.mreq    = strobePhase;
          strb.rd      = strobePhase;
          strb.capture = isFinal;
        end
        KIND_MEM_WR: begin
          strb.mreq      = strobePhase;
          strb.wr        = strobePhase;
          strb.driveData = 1'b1;
        end
        KIND_IO_RD: begin
          strb.iorq    = strobePhase;
          strb.rd      = strobePhase;
          strb.capture = isFinal;
        end
        KIND_IO_WR: begin
          strb.iorq      = strobePhase;
          strb.wr        = strobePhase;
          strb.driveData = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      haltQ <= 1'b0;
      kindQ <= KIND_FETCH;
      tCnt  <= '0;
    end else if (strb.accept) begin
      busy  <= 1'b1;
      haltQ <= haltFlag;
      kindQ <= cycKindT'(reqKind);
      tCnt  <= T_W'(1);
    end else if (busy) begin
      if (isFinal) begin
        busy <= 1'b0;
        tCnt <= '0;
      end else begin
        tCnt <= tCnt + T_W'(1);
      end
    end
  end

  // R10: a running cycle keeps its kind until its final T-state.
  a_r10_kind_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isFinal) |=> (busy && kindQ == $past(kindQ)));

  // R9: an illegal kind never leaves the idle state.
  a_r9_illegal_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !kindLegal(reqKind)) |=> !busy);

endmodule

// File: rtl/busSeqPath.sv
module busSeqPath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REF_W  = 7,
  localparam int REG_W = REF_W + 1,
  localparam int IV_W  = ADDR_W - REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobesT        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [IV_W-1:0]   ivReg,
  input  logic              refreshLoad,
  input  logic [REG_W-1:0]  refreshLoadVal,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              pcStep,
  output logic [REG_W-1:0]  refreshVal
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrQ;
  logic [DATA_W-1:0] rdQ;
  logic [REG_W-1:0]  refQ;
  logic              doneQ;
  logic              stepQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      wrQ   <= '0;
      rdQ   <= '0;
      refQ  <= '0;
      doneQ <= 1'b0;
      stepQ <= 1'b0;
    end else begin
      if (strb.accept) begin
        addrQ <= reqAddr;
        wrQ   <= reqWrData;
      end
      if (strb.capture) begin
        rdQ <= strb.forceZero ? '0 : busDataIn;
      end
      if (strb.idle && refreshLoad) begin
        refQ <= refreshLoadVal;
      end else if (strb.bumpRefresh) begin
        refQ <= {refQ[REG_W-1], refQ[REF_W-1:0] + REF_W'(1)};
      end
      doneQ <= strb.finish;
      stepQ <= strb.finish && strb.stepPc;
    end
  end

  always_comb begin
    if (strb.rfsh)      busAddr = {ivReg, refQ};
    else if (strb.idle) busAddr = '0;
    else                busAddr = addrQ;
  end

  assign busDataOut = strb.driveData ? wrQ : '0;
  assign rdData     = rdQ;
  assign done       = doneQ;
  assign pcStep     = stepQ;
  assign refreshVal = refQ;

  // R6: a fetch end steps the low bits by one and keeps the top bit.
  a_r6_refresh_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.bumpRefresh) |->
      (refQ[REG_W-1] == $past(refQ[REG_W-1]) &&
       refQ[REF_W-1:0] == $past(refQ[REF_W-1:0]) + REF_W'(1)));

  // R3: write cycles do not disturb the captured read data.
  a_r3_rd_kept: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveData |=> $stable(rdQ));

endmodule

// File: rtl/busSequencer.sv
module busSequencer
  import busSeqPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int REF_W    = 7,
  parameter int MEM_T    = 3,
  parameter int IO_EXTRA = 3,
  localparam int REG_W   = REF_W + 1,
  localparam int IV_W    = ADDR_W - REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              haltFlag,
  input  logic [IV_W-1:0]   ivReg,
  input  logic              refreshLoad,
  input  logic [REG_W-1:0]  refreshLoadVal,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              m1N,
  output logic              mreqN,
  output logic              iorqN,
  output logic              rdN,
  output logic              wrN,
  output logic              rfshN,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              pcStep,
  output logic              idle,
  output logic [REG_W-1:0]  refreshVal
);

  seqStrobesT strb;

  busSeqCtrl #(.MEM_T(MEM_T), .IO_EXTRA(IO_EXTRA)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .haltFlag (haltFlag),
    .strb     (strb)
  );

  busSeqPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REF_W(REF_W)) i_path (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .reqAddr        (reqAddr),
    .reqWrData      (reqWrData),
    .ivReg          (ivReg),
    .refreshLoad    (refreshLoad),
    .refreshLoadVal (refreshLoadVal),
    .busDataIn      (busDataIn),
    .busAddr        (busAddr),
    .busDataOut     (busDataOut),
    .rdData         (rdData),
    .done           (done),
    .pcStep         (pcStep),
    .refreshVal     (refreshVal)
  );

  assign m1N   = ~strb.m1;
  assign mreqN = ~strb.mreq;
  assign iorqN = ~strb.iorq;
  assign rdN   = ~strb.rd;
  assign wrN   = ~strb.wr;
  assign rfshN = ~strb.rfsh;
  assign idle  = strb.idle;

  // R8: memory and I/O space are never requested together.
  a_r8_single_space: assert property (@(posedge clk) disable iff (!rstN)
    !(!mreqN && !iorqN));

  // R2: read and write strobes are never low together.
  a_r2_rd_wr_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R5: the refresh phase shows the vector byte above the counter.
  a_r5_refresh_addr: assert property (@(posedge clk) disable iff (!rstN)
    !rfshN |-> (busAddr == {ivReg, refreshVal} && !mreqN && m1N && rdN));

  // R1: an idle bus keeps every strobe released.
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (m1N && mreqN && iorqN && rdN && wrN && rfshN));

endmodule

// File: tb/test_busSequencer.sv
`timescale 1ns/1ps
module test_busSequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWrData = 8'h0;
  logic        haltFlag = 1'b0;
  logic [7:0]  ivReg = 8'h9C;
  logic        refreshLoad = 1'b0;
  logic [7:0]  refreshLoadVal = 8'h0;
  logic [7:0]  busDataIn = 8'h0;
  logic [15:0] busAddr;
  logic [7:0]  busDataOut;
  logic        m1N, mreqN, iorqN, rdN, wrN, rfshN;
  logic [7:0]  rdData;
  logic        done, pcStep, idle;
  logic [7:0]  refreshVal;

  int nChecks = 0;
  int nFails  = 0;

  // Models kept by the bench.
  logic [7:0] refExp = 8'h00;
  logic [7:0] rdExp  = 8'h00;

  always #2.5 clk = ~clk;

  busSequencer i_busSequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .haltFlag(haltFlag),
    .ivReg(ivReg), .refreshLoad(refreshLoad), .refreshLoadVal(refreshLoadVal),
    .busDataIn(busDataIn), .busAddr(busAddr), .busDataOut(busDataOut),
    .m1N(m1N), .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN),
    .rfshN(rfshN), .rdData(rdData), .done(done), .pcStep(pcStep),
    .idle(idle), .refreshVal(refreshVal)
  );

  // Vector: kind[35:33] addr[32:17] wdata[16:9] din[8:1] halt[0]
  localparam int NVEC = 8;
  localparam logic [35:0] VECS [NVEC] = '{
    {3'd0, 16'h1234, 8'h00, 8'h3E, 1'b0},
    {3'd1, 16'h8001, 8'h00, 8'hA5, 1'b0},
    {3'd2, 16'h4002, 8'h5A, 8'h11, 1'b0},
    {3'd3, 16'h00FE, 8'h00, 8'h77, 1'b0},
    {3'd4, 16'h12FF, 8'hC3, 8'h22, 1'b0},
    {3'd0, 16'h2000, 8'h00, 8'hFF, 1'b1},
    {3'd0, 16'hFFFF, 8'h00, 8'h01, 1'b0},
    {3'd1, 16'h0000, 8'h00, 8'h00, 1'b0}
  };

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic string kindTag(input logic [2:0] k);
    case (k)
      3'd0: return "R4/R5 fetch";
      3'd1: return "R2 memory read";
      3'd2: return "R3 memory write";
      default: return "R8 io cycle";
    endcase
  endfunction

  function automatic int tCount(input logic [2:0] k);
    if (k == 3'd0) return 4;
    if (k >= 3'd3) return 6;
    return 3;
  endfunction

  // Expected {m1N,mreqN,iorqN,rdN,wrN,rfshN} per requirement text.
  function automatic logic [5:0] expStrobes(input logic [2:0] k, input int t);
    logic m1, mreq, iorq, rd, wr, rfsh;
    m1 = 0; mreq = 0; iorq = 0; rd = 0; wr = 0; rfsh = 0;
    case (k)
      3'd0: begin m1 = (t <= 2); mreq = (t >= 2); rd = (t == 2); rfsh = (t >= 3); end
      3'd1: begin mreq = (t >= 2); rd = (t >= 2); end
      3'd2: begin mreq = (t >= 2); wr = (t >= 2); end
      3'd3: begin iorq = (t >= 2); rd = (t >= 2); end
      3'd4: begin iorq = (t >= 2); wr = (t >= 2); end
      default: ;
    endcase
    return ~{m1, mreq, iorq, rd, wr, rfsh};
  endfunction

  task automatic runCycle(input logic [2:0] k, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] din,
                          input logic h);
    int nT;
    logic [15:0] ea;
    logic [7:0]  ed;
    nT = tCount(k);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWrData = wd;
    haltFlag = h; busDataIn = din;
    @(negedge clk);
    reqValid = 1'b0;
    for (int t = 1; t <= nT; t++) begin
      if (t > 1) @(negedge clk);
      ea = (k == 3'd0 && t >= 3) ? {ivReg, refExp} : a;
      ed = (k == 3'd2 || k == 3'd4) ? wd : 8'h00;
      check({m1N, mreqN, iorqN, rdN, wrN, rfshN} == expStrobes(k, t),
            {kindTag(k), " strobes"}, {26'd0, m1N, mreqN, iorqN, rdN, wrN, rfshN},
            {26'd0, expStrobes(k, t)});
      check(busAddr == ea && busDataOut == ed && !idle && !done,
            {kindTag(k), " addr/data"}, {busAddr, busDataOut, 8'd0},
            {ea, ed, 8'd0});
    end
    @(negedge clk);
    if (k == 3'd0) begin
      rdExp  = h ? 8'h00 : din;
      refExp = {refExp[7], refExp[6:0] + 7'd1};
    end else if (k == 3'd1 || k == 3'd3) begin
      rdExp = din;
    end
    check(done && idle && rdData == rdExp, {kindTag(k), " done/rdData"},
          {23'd0, done, rdData}, {23'd0, 1'b1, rdExp});
    check(pcStep == (k == 3'd0 && !h), "R7 pcStep", {31'd0, pcStep},
          {31'd0, (k == 3'd0 && !h)});
    check(refreshVal == refExp, "R6 refresh counter", {24'd0, refreshVal},
          {24'd0, refExp});
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset state.
    repeat (3) @(negedge clk);
    check({m1N, mreqN, iorqN, rdN, wrN, rfshN} == 6'h3F && idle && !done && !pcStep,
          "R1 reset strobes", {24'd0, m1N, mreqN, iorqN, rdN, wrN, rfshN, idle, done},
          32'hFE);
    check(refreshVal == 8'h00 && rdData == 8'h00 && busAddr == 16'h0 && busDataOut == 8'h0,
          "R1 reset datapath", {refreshVal, rdData, busAddr}, 32'h0);
    rstN = 1'b1;

    // Table walk: R2, R3, R4, R5, R6, R7, R8.
    for (int i = 0; i < NVEC; i++) begin
      runCycle(VECS[i][35:33], VECS[i][32:17], VECS[i][16:9], VECS[i][8:1], VECS[i][0]);
    end

    // R9: codes 5..7 start nothing.
    for (int c = 5; c <= 7; c++) begin
      @(negedge clk);
      reqValid = 1'b1; reqKind = 3'(c); reqAddr = 16'hABCD;
      @(negedge clk);
      reqValid = 1'b0;
      check(idle && {m1N, mreqN, iorqN, rdN, wrN, rfshN} == 6'h3F && busAddr == 16'h0,
            "R9 illegal kind", {15'd0, idle, busAddr}, {15'd0, 1'b1, 16'h0});
      @(negedge clk);
      check(!done && idle, "R9 no done", {30'd0, done, idle}, 32'h1);
    end

    // R10: request during a running read is ignored.
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd1; reqAddr = 16'h3333; busDataIn = 8'h6C;
    @(negedge clk);                       // T1
    reqValid = 1'b0;
    check(!idle, "R10 busy flag", {31'd0, idle}, 32'h0);
    @(negedge clk);                       // T2
    reqValid = 1'b1; reqKind = 3'd2; reqAddr = 16'h5555; reqWrData = 8'hEE;
    @(negedge clk);                       // T3
    check(busAddr == 16'h3333 && wrN && !rdN, "R10 cycle unchanged",
          {busAddr, 14'd0, wrN, rdN}, {16'h3333, 14'd0, 1'b1, 1'b0});
    reqValid = 1'b0;
    @(negedge clk);                       // done
    rdExp = 8'h6C;
    check(done && rdData == 8'h6C, "R10 read completes", {23'd0, done, rdData},
          {23'd0, 1'b1, 8'h6C});
    @(negedge clk);
    check(idle && wrN && mreqN && busDataOut == 8'h00, "R10 no late write",
          {22'd0, idle, wrN, busDataOut}, {22'd0, 2'b11, 8'h00});

    // R6: load while idle, then wrap low bits with bit 7 kept.
    @(negedge clk);
    refreshLoad = 1'b1; refreshLoadVal = 8'hFF;
    @(negedge clk);
    refreshLoad = 1'b0;
    refExp = 8'hFF;
    check(refreshVal == 8'hFF, "R6 refresh load", {24'd0, refreshVal}, 32'hFF);
    ivReg = 8'h31;
    runCycle(3'd0, 16'h0100, 8'h00, 8'hC9, 1'b0);
    check(refreshVal == 8'h80, "R6 wrap keeps bit 7", {24'd0, refreshVal}, 32'h80);

    // R6: a load attempted mid-cycle has no effect.
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd1; reqAddr = 16'h0042; busDataIn = 8'h10;
    @(negedge clk);
    reqValid = 1'b0;
    refreshLoad = 1'b1; refreshLoadVal = 8'h05;
    @(negedge clk);
    refreshLoad = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(refreshVal == 8'h80 && done, "R6 load ignored when busy",
          {23'd0, done, refreshVal}, {23'd0, 1'b1, 8'h80});

    finishRun();
  end

endmodule